// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block holds interrupt requests that are waiting for a processor core. Each request is named by an 8-bit vector. The arbiter picks the one vector with the highest priority and offers it to the core. A vector's priority comes from its number alone. The upper four bits give its class, and the lower four bits set its order inside that class. Vectors 0 to 15 form class 0, which is illegal, so they are never stored and never offered.

Two things can hold back delivery. Software writes a threshold level, and the block also tracks the class of the highest vector the core is still servicing. The larger of these two values is the processor priority, and it is shown on an output port. A waiting vector goes out only if its class is strictly above the processor priority. The core takes the offered vector by acknowledging it, which moves the vector from waiting to in-service. An end-of-interrupt pulse retires the highest in-service vector. Retiring it can lower the processor priority, and a vector that was held back may then be offered.

Top module: `vec_prio_arb`

## Requirements
- R1: After a synchronous reset, no vector is waiting or in service, the threshold is 0, `dlv_valid` is 0 and `proc_prio` is 0.
- R2: The class of a vector is bits 7:4. A vector of a higher class is offered before any vector of a lower class.
- R3: Among waiting vectors of the same class, the one with the larger bits 3:0 is offered first.
- R4: A request for a vector from 0 to 15 (class 0) is ignored and never offered, even when the threshold is 0.
- R5: `proc_prio` equals the larger of the threshold and the class of the highest in-service vector. A vector is offered only if its class is strictly greater than `proc_prio`, so a threshold of 0 lets every legal class through.
- R6: `dlv_valid` and `dlv_vec` are registered. They rise one clock edge after a vector becomes eligible, and they stay stable until `dlv_ack` is seen. A request of higher priority that arrives while an offer is open does not change the offer.
- R7: On an edge where `dlv_valid` and `dlv_ack` are both high, the offered vector stops waiting, enters service and `dlv_valid` drops. `proc_prio` shows the new in-service class straight after that edge.
- R8: A pulse on `eoi` retires only the highest in-service vector. A waiting vector that was masked by it is offered on the next edge after the retirement.
- R9: Requesting a vector that is already waiting merges with the earlier request, so the vector is offered only once.
- R10: Requesting a vector while that same vector is in service makes it wait again, and it is offered again once the in-service copy is retired.
- R11: A write of `tpr_wdata` with `tpr_we` takes effect at the next edge and shows on `proc_prio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Vector being requested |
| tpr_we | input | 1 | Threshold write strobe |
| tpr_wdata | input | 4 | New threshold level |
| dlv_valid | output | 1 | A vector is offered to the core |
| dlv_vec | output | 8 | Offered vector |
| dlv_ack | input | 1 | Core takes the offered vector |
| eoi | input | 1 | Retire the highest in-service vector |
| proc_prio | output | 4 | Current processor priority |

## Verification
A stale in-service bit shows up on `proc_prio` in the cycle right after the acknowledge or retirement that should have changed it. A lost or doubled waiting bit shows up as a missing or repeated offer within two edges of the request or retirement. A wrong comparison between class and priority shows up as an offer that appears when the class is masked, or that is missing when it is not. The tests therefore sample `proc_prio` straight after each acknowledge and retirement, and they watch `dlv_valid` for a short window after each change.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
  localparam int VEC_W = 8;
  localparam int CLS_W = 4;
  localparam int SUB_W = VEC_W - CLS_W;
  localparam int NVEC  = 1 << VEC_W;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  function automatic cls_t cls_of(input vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction
endpackage

// File: rtl/vpa_hi_find.sv
module vpa_hi_find #(
  parameter int IDX_W = 8,
  parameter int GRP_W = 4
) (
  input  logic [(1<<IDX_W)-1:0] bits,
  output logic                  found,
  output logic [IDX_W-1:0]      idx
);
  localparam int NG   = 1 << (IDX_W - GRP_W);
  localparam int G    = 1 << GRP_W;
  localparam int HI_W = IDX_W - GRP_W;

  logic [NG-1:0]    grp_any;
  logic [HI_W-1:0]  grp_sel;
  logic [GRP_W-1:0] sub_sel;

  generate
    for (genvar gi = 0; gi < NG; gi++) begin : g_grp
      assign grp_any[gi] = |bits[gi*G +: G];
    end
  endgenerate

  always_comb begin
    grp_sel = '0;
    for (int g = 0; g < NG; g++)
      if (grp_any[g]) grp_sel = HI_W'(g);
    sub_sel = '0;
    for (int s = 0; s < G; s++)
      if (bits[{grp_sel, GRP_W'(s)}]) sub_sel = GRP_W'(s);
  end

  assign found = |grp_any;
  assign idx   = {grp_sel, sub_sel};
endmodule

// File: rtl/vpa_vec_state.sv
module vpa_vec_state
  import vpa_pkg::*;
#(
  parameter int IDX_W = VEC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_en,
  input  logic [IDX_W-1:0]      req_idx,
  input  logic                  ack_en,
  input  logic [IDX_W-1:0]      ack_idx,
  input  logic                  ret_en,
  input  logic [IDX_W-1:0]      ret_idx,
  output logic [(1<<IDX_W)-1:0] pend,
  output logic [(1<<IDX_W)-1:0] isr
);
  localparam int N = 1 << IDX_W;
  localparam logic [N-1:0] ONE = N'(1);

  logic [N-1:0] req_m, ack_m, ret_m;

  assign req_m = req_en ? (ONE << req_idx) : '0;
  assign ack_m = ack_en ? (ONE << ack_idx) : '0;
  assign ret_m = ret_en ? (ONE << ret_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      isr  <= '0;
    end else begin
      pend <= (pend & ~ack_m) | req_m;
      isr  <= (isr & ~ret_m) | ack_m;
    end
  end

  // R7: an acknowledged vector is in service at the next edge
  a_r7_ack_enters_service: assert property (@(posedge clk) disable iff (rst)
    ack_en |=> isr[$past(ack_idx)]);

  // R7: it stops waiting unless it was requested again in that cycle
  a_r7_ack_leaves_pending: assert property (@(posedge clk) disable iff (rst)
    ack_en && !(req_en && req_idx == ack_idx) |=> !pend[$past(ack_idx)]);

  // R8: the retired vector is gone from service
  a_r8_retire_clears: assert property (@(posedge clk) disable iff (rst)
    ret_en && !(ack_en && ack_idx == ret_idx) |=> !isr[$past(ret_idx)]);
endmodule

// File: rtl/vec_prio_arb.sv
module vec_prio_arb
  import vpa_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vec,
  input  logic             tpr_we,
  input  logic [CLS_W-1:0] tpr_wdata,
  output logic             dlv_valid,
  output logic [VEC_W-1:0] dlv_vec,
  input  logic             dlv_ack,
  input  logic             eoi,
  output logic [CLS_W-1:0] proc_prio
);
  logic [NVEC-1:0] pend, isr;
  logic            pend_found, isr_found;
  vec_t            pend_top, isr_top;
  cls_t            tpr_q, isr_cls;
  logic            req_legal, ack_fire, eligible;

  // R4: class 0 never enters the waiting set
  assign req_legal = req_valid && (cls_of(req_vec) != '0);
  assign ack_fire  = dlv_valid && dlv_ack;

  vpa_vec_state #(.IDX_W(VEC_W)) u_state (
    .clk     (clk),
    .rst     (rst),
    .req_en  (req_legal),
    .req_idx (req_vec),
    .ack_en  (ack_fire),
    .ack_idx (dlv_vec),
    .ret_en  (eoi && isr_found),
    .ret_idx (isr_top),
    .pend    (pend),
    .isr     (isr)
  );

  vpa_hi_find #(.IDX_W(VEC_W), .GRP_W(SUB_W)) u_find_pend (
    .bits  (pend),
    .found (pend_found),
    .idx   (pend_top)
  );

  vpa_hi_find #(.IDX_W(VEC_W), .GRP_W(SUB_W)) u_find_isr (
    .bits  (isr),
    .found (isr_found),
    .idx   (isr_top)
  );

  always_ff @(posedge clk) begin
    if (rst)         tpr_q <= '0;
    else if (tpr_we) tpr_q <= tpr_wdata;
  end

  assign isr_cls   = isr_found ? cls_of(isr_top) : '0;
  assign proc_prio = (isr_cls > tpr_q) ? isr_cls : tpr_q;
  assign eligible  = pend_found && (cls_of(pend_top) > proc_prio);

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid <= 1'b0;
      dlv_vec   <= '0;
    end else if (dlv_valid) begin
      if (dlv_ack) dlv_valid <= 1'b0;
    end else if (eligible) begin
      dlv_valid <= 1'b1;
      dlv_vec   <= pend_top;
    end
  end

  // R4: nothing from class 0 is ever offered
  a_r4_legal_only: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> cls_of(dlv_vec) != '0);

  // R6: an open offer holds until acknowledged
  a_r6_offer_held: assert property (@(posedge clk) disable iff (rst)
    dlv_valid && !dlv_ack |=> dlv_valid && $stable(dlv_vec));

  // R5: a new offer is above the priority that held in the cycle before
  a_r5_above_prio: assert property (@(posedge clk) disable iff (rst)
    $rose(dlv_valid) |-> cls_of(dlv_vec) > $past(proc_prio));

  // R2: the chosen waiting vector really is waiting
  a_r2_pick_is_pending: assert property (@(posedge clk) disable iff (rst)
    pend_found |-> pend[pend_top]);

  // R5: the processor priority never falls below the threshold
  a_r5_prio_floor: assert property (@(posedge clk) disable iff (rst)
    proc_prio >= tpr_q);
endmodule

// File: tb/vec_prio_arb_test.sv
module vec_prio_arb_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [7:0] req_vec = '0;
  logic       tpr_we = 1'b0;
  logic [3:0] tpr_wdata = '0;
  logic       dlv_valid;
  logic [7:0] dlv_vec;
  logic       dlv_ack = 1'b0;
  logic       eoi = 1'b0;
  logic [3:0] proc_prio;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  vec_prio_arb uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vec(req_vec),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .dlv_valid(dlv_valid),
    .dlv_vec(dlv_vec), .dlv_ack(dlv_ack), .eoi(eoi), .proc_prio(proc_prio)
  );

  // {threshold, first request, second request, expect offer, expected vector}
  localparam int NT = 9;
  localparam logic [28:0] TBL [NT] = '{
    {4'd0,  8'h35, 8'h52, 1'b1, 8'h52},   // R2 higher class wins
    {4'd0,  8'h57, 8'h5A, 1'b1, 8'h5A},   // R3 higher sub-order wins
    {4'd0,  8'h0F, 8'h03, 1'b0, 8'h00},   // R4 class 0 ignored
    {4'd5,  8'h52, 8'h41, 1'b0, 8'h00},   // R5 class equal to threshold masked
    {4'd5,  8'h61, 8'h41, 1'b1, 8'h61},   // R5 class above threshold
    {4'd0,  8'h10, 8'h0E, 1'b1, 8'h10},   // R5 threshold 0, lowest legal
    {4'd15, 8'hFF, 8'h20, 1'b0, 8'h00},   // R5 top threshold masks all
    {4'd14, 8'hF0, 8'hEF, 1'b1, 8'hF0},   // R2 class beats sub-order
    {4'd0,  8'h0A, 8'h11, 1'b1, 8'h11}    // R4 mixed legal and illegal
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
  endtask

  task automatic send(input logic [7:0] v);
    req_valid = 1'b1; req_vec = v; tick(); req_valid = 1'b0;
  endtask

  task automatic set_tpr(input logic [3:0] t);
    tpr_we = 1'b1; tpr_wdata = t; tick(); tpr_we = 1'b0;
  endtask

  task automatic ack();
    dlv_ack = 1'b1; tick(); dlv_ack = 1'b0;
  endtask

  task automatic retire();
    eoi = 1'b1; tick(); eoi = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    tick();
    do_reset();
    // R1 reset state
    chk("R1 dlv_valid", 32'(dlv_valid), 0);
    chk("R1 proc_prio", 32'(proc_prio), 0);

    for (int i = 0; i < NT; i++) begin
      do_reset();
      set_tpr(4'd15);
      send(TBL[i][24:17]);
      send(TBL[i][16:9]);
      set_tpr(TBL[i][28:25]);
      tick();
      chk($sformatf("R2/R3/R4/R5 row%0d valid", i), 32'(dlv_valid), 32'(TBL[i][8]));
      if (TBL[i][8]) chk($sformatf("R2/R3/R5 row%0d vec", i), 32'(dlv_vec), 32'(TBL[i][7:0]));
    end

    // R11 threshold write visible next edge
    do_reset();
    set_tpr(4'd7);
    chk("R11 proc_prio", 32'(proc_prio), 7);
    set_tpr(4'd0);

    // R6 offer held, R7 ack, R8 retire order
    send(8'h40);
    tick();
    chk("R6 first offer", 32'({dlv_valid, dlv_vec}), 32'({1'b1, 8'h40}));
    send(8'h90);
    tick(); tick();
    chk("R6 held offer", 32'({dlv_valid, dlv_vec}), 32'({1'b1, 8'h40}));
    ack();
    chk("R7 prio after ack", 32'(proc_prio), 4);
    tick();
    chk("R7 next offer", 32'({dlv_valid, dlv_vec}), 32'({1'b1, 8'h90}));
    ack();
    chk("R7 prio nested", 32'(proc_prio), 9);
    retire();
    chk("R8 retire highest", 32'(proc_prio), 4);
    retire();
    chk("R8 retire last", 32'(proc_prio), 0);

    // R8 masked vector released by retirement
    do_reset();
    send(8'h80); tick(); ack();
    send(8'h50); tick(); tick(); tick();
    chk("R8 masked", 32'(dlv_valid), 0);
    retire(); tick();
    chk("R8 released", 32'({dlv_valid, dlv_vec}), 32'({1'b1, 8'h50}));

    // R9 duplicate request merged
    do_reset();
    send(8'h33); send(8'h33); tick();
    chk("R9 offer", 32'({dlv_valid, dlv_vec}), 32'({1'b1, 8'h33}));
    ack(); retire(); tick(); tick();
    chk("R9 no repeat", 32'(dlv_valid), 0);

    // R10 re-request while in service
    do_reset();
    send(8'h44); tick(); ack();
    send(8'h44); tick(); tick();
    chk("R10 held while in service", 32'(dlv_valid), 0);
    retire(); tick();
    chk("R10 offered again", 32'({dlv_valid, dlv_vec}), 32'({1'b1, 8'h44}));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule